// File: doc/BRIEF.md
# Mode-Banked Nibble Register File

This block sits behind a serial access front end and turns nibble-wide register accesses into reads and writes of one of several banks. A two-bit mode field, kept in a control register that is visible in every bank, picks the bank. In the time bank the front end sees thirteen calendar counter nibbles and three control registers. In the two RAM banks it sees one half of a 120-nibble user RAM and the control register that holds the mode field. Every register applies its own write mask. Fixed-zero bits, read-only status bits and gaps in the address space read back as zero.

The block also holds a power-on-clear flag and runs a self-clearing system reset. Writing a one to the system-reset bit puts every control bit and counter nibble into its initial state and keeps it there. The user RAM is left alone. The block then waits for a rising edge on the chip-select level, and after that for a falling edge on the serial-clock level. The release is handled by a three-state sequencer:
- `SQ_IDLE` goes to `SQ_WAIT_CS` on a system-reset write.
- `SQ_WAIT_CS` goes to `SQ_WAIT_SCK` on a chip-select rise.
- `SQ_WAIT_SCK` goes back to `SQ_IDLE` on a serial-clock fall. This last transition also clears the power-on-clear flag.

Counting and the serial framing are done elsewhere. Writes take effect on the clock edge at which `wr_stb` is sampled high. `rdata` is a combinational function of `addr` and the stored state.

Top module: `nibble_bank_regs`

## Requirements
- R1: When mode is 00 or 01, addresses 0–12 select the counter nibbles, 61 selects CTRL_A, 62 selects CTRL_B and 63 selects CTRL_C. Every other address reads 0 and ignores writes.
- R2: Mode 10 maps addresses 0–59 to RAM nibbles 0–59, and mode 11 maps them to RAM nibbles 60–119. In both RAM modes, address 63 is CTRL_C. Addresses 60–62 read 0 and ignore writes, so CTRL_A and CTRL_B keep their values.
- R3: Each counter nibble has a write mask: 0xF at addresses 0, 2, 4, 7, 9, 11, 12; 0x7 at 1, 3, 6; 0xB at 5; 0x3 at 8; 0x1 at 10. Bits outside the mask read 0. CTRL_A holds a pulse-select bit in [3] and an adjust bit in [2]; its bits [1:0] are fixed zero.
- R4: CTRL_B has four bits. [3] is the power-on-clear flag and is read-only. [2] is busy; it reads 0 and discards writes. [1] selects 24-hour format. [0] is the counter clear bit.
- R5: CTRL_C has four bits. [3] is system reset. [2] is a stored write-zero-only test bit. [1:0] is the mode field.
- R6: While rst_n is low, the counters take their initial values: 2 at address 4, 1 at addresses 5, 7 and 9, and 0 elsewhere. All control bits are set to 0 and the power-on-clear flag is set to 1.
- R7: After a write of 1 to CTRL_C[3], the system-reset bit reads 1 and all other control bits read 0, except the power-on-clear flag. The counters return to their initial values and the RAM keeps its contents. All writes are ignored while system reset is held.
- R8: System reset clears only on the clock edge that samples a serial-clock fall, and only after a chip-select rise (a 0 then 1 sample) has been seen. A serial-clock fall before that rise has no effect, and so does a chip-select rise on its own.
- R9: The power-on-clear flag clears on the same edge that releases system reset. Only rst_n sets it again.
- R10: While the counter clear bit is 1, the counter nibbles read their initial values and counter writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cs_lvl | input | 1 | Chip-select level, sampled every clock |
| sck_lvl | input | 1 | Serial-clock level, sampled every clock |
| wr_stb | input | 1 | Write strobe for one cycle |
| addr | input | 6 | Register address within the current bank |
| wdata | input | 4 | Write nibble |
| rdata | output | 4 | Read nibble for `addr` in the current bank |

## Verification
A corrupt mode field appears at once at `rdata` as the wrong bank, because the read path is combinational. A sequencer stuck in the wrong state shows within a cycle in the system-reset bit of CTRL_C. The power-on-clear bit changes on the same release edge, which ties its error to the sequencer's. A missed mask or init value appears on the first read of the affected nibble after the write or reset. The checks therefore read back every masked field right after writing it. They also read the system-reset bit after each chip-select and serial-clock transition.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

    localparam int NIB_W    = 4;
    localparam int ADDR_W   = 6;
    localparam int CAL_N    = 13;
    localparam int RAM_HALF = 60;
    localparam int RAM_N    = 2 * RAM_HALF;
    localparam int RAM_AW   = $clog2(RAM_N);
    localparam int CAL_IW   = $clog2(CAL_N);

    localparam logic [ADDR_W-1:0] A_CTRL_A = ADDR_W'(61);
    localparam logic [ADDR_W-1:0] A_CTRL_B = ADDR_W'(62);
    localparam logic [ADDR_W-1:0] A_CTRL_C = ADDR_W'(63);

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_WAIT_CS,
        SQ_WAIT_SCK
    } sq_state_t;

    function automatic logic [NIB_W-1:0] cal_mask(input int idx);
        case (idx)
            1, 3, 6: return 4'h7;
            5:       return 4'hB;
            8:       return 4'h3;
            10:      return 4'h1;
            default: return 4'hF;
        endcase
    endfunction

    function automatic logic [NIB_W-1:0] cal_init(input int idx);
        case (idx)
            4:       return 4'h2;
            5, 7, 9: return 4'h1;
            default: return 4'h0;
        endcase
    endfunction

endpackage

// File: rtl/nbr_sysr_seq.sv
module nbr_sysr_seq
    import nbr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic cs_lvl,
    input  logic sck_lvl,
    output logic sysr_on,
    output logic release_now
);

    sq_state_t state_q, state_d;
    logic cs_q, sck_q;
    logic cs_rise, sck_fall;

    assign cs_rise  = cs_lvl & ~cs_q;
    assign sck_fall = sck_q & ~sck_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cs_q    <= 1'b1;
            sck_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cs_q    <= cs_lvl;
            sck_q   <= sck_lvl;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:     if (set_req)  state_d = SQ_WAIT_CS;
            SQ_WAIT_CS:  if (cs_rise)  state_d = SQ_WAIT_SCK;
            SQ_WAIT_SCK: if (sck_fall) state_d = SQ_IDLE;
            default:                   state_d = SQ_IDLE;
        endcase
    end

    always_comb begin
        sysr_on     = 1'b0;
        release_now = 1'b0;
        unique case (state_q)
            SQ_IDLE:     sysr_on = 1'b0;
            SQ_WAIT_CS:  sysr_on = 1'b1;
            SQ_WAIT_SCK: begin
                sysr_on     = 1'b1;
                release_now = sck_fall;
            end
            default:     sysr_on = 1'b0;
        endcase
    end

endmodule

// File: rtl/nbr_cal_regs.sv
module nbr_cal_regs
    import nbr_pkg::*;
#(
    parameter int N  = CAL_N,
    parameter int IW = CAL_IW,
    parameter int W  = NIB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_req,
    input  logic          wr_en,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rd
);

    logic [W-1:0] nib_q [N];

    for (genvar g = 0; g < N; g++) begin : g_nib
        localparam logic [W-1:0] MASK = cal_mask(g);
        localparam logic [W-1:0] INIT = cal_init(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              nib_q[g] <= INIT;
            else if (init_req)                       nib_q[g] <= INIT;
            else if (wr_en && idx == IW'(g))         nib_q[g] <= wdata & MASK;
        end
    end

    always_comb begin
        rd = '0;
        for (int i = 0; i < N; i++) begin
            if (idx == IW'(i)) rd = nib_q[i];
        end
    end

endmodule

// File: rtl/nbr_user_ram.sv
module nbr_user_ram
    import nbr_pkg::*;
#(
    parameter int DEPTH = RAM_N,
    parameter int AW    = RAM_AW,
    parameter int W     = NIB_W
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] a,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rd
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[a] <= wdata;
    end

    assign rd = (32'(a) < DEPTH) ? mem[a] : '0;

endmodule

// File: rtl/nibble_bank_regs.sv
module nibble_bank_regs
    import nbr_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int W    = NIB_W,
    parameter int HALF = RAM_HALF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_lvl,
    input  logic          sck_lvl,
    input  logic          wr_stb,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    localparam int RAW = $clog2(2 * HALF);
    localparam logic [AW-1:0] CAL_LIM  = AW'(CAL_N);
    localparam logic [AW-1:0] HALF_LIM = AW'(HALF);

    logic [1:0] mode_q;
    logic       tst_q, tps_q, adj_q, fmt_q, cnt_q, ponc_q;
    logic       sysr_on, release_now;
    logic       in_time, wr_ok, set_sysr;
    logic       cal_wr, ram_wr;
    logic [W-1:0]   cal_rd, ram_rd;
    logic [RAW-1:0] ram_a;

    assign in_time  = ~mode_q[1];
    assign wr_ok    = wr_stb & ~sysr_on;
    assign set_sysr = wr_ok && addr == A_CTRL_C && wdata[3];
    assign cal_wr   = wr_ok && in_time && addr < CAL_LIM;
    assign ram_wr   = wr_ok && !in_time && addr < HALF_LIM;
    assign ram_a    = RAW'(addr) + (mode_q[0] ? RAW'(HALF) : '0);

    nbr_sysr_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_req     (set_sysr),
        .cs_lvl      (cs_lvl),
        .sck_lvl     (sck_lvl),
        .sysr_on     (sysr_on),
        .release_now (release_now)
    );

    nbr_cal_regs u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_req (sysr_on | cnt_q),
        .wr_en    (cal_wr),
        .idx      (addr[CAL_IW-1:0]),
        .wdata    (wdata),
        .rd       (cal_rd)
    );

    nbr_user_ram #(.DEPTH(2 * HALF), .AW(RAW), .W(W)) u_ram (
        .clk   (clk),
        .wr_en (ram_wr),
        .a     (ram_a),
        .wdata (wdata),
        .rd    (ram_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            tst_q  <= 1'b0;
            tps_q  <= 1'b0;
            adj_q  <= 1'b0;
            fmt_q  <= 1'b0;
            cnt_q  <= 1'b0;
            ponc_q <= 1'b1;
        end else begin
            if (release_now) ponc_q <= 1'b0;
            if (sysr_on || set_sysr) begin
                mode_q <= '0;
                tst_q  <= 1'b0;
                tps_q  <= 1'b0;
                adj_q  <= 1'b0;
                fmt_q  <= 1'b0;
                cnt_q  <= 1'b0;
            end else if (wr_ok) begin
                if (addr == A_CTRL_C) begin
                    mode_q <= wdata[1:0];
                    tst_q  <= wdata[2];
                end else if (in_time && addr == A_CTRL_A) begin
                    tps_q <= wdata[3];
                    adj_q <= wdata[2];
                end else if (in_time && addr == A_CTRL_B) begin
                    fmt_q <= wdata[1];
                    cnt_q <= wdata[0];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL_C) begin
            rdata = {sysr_on, tst_q, mode_q};
        end else if (in_time) begin
            if (addr < CAL_LIM)        rdata = cal_rd;
            else if (addr == A_CTRL_A) rdata = {tps_q, adj_q, 2'b00};
            else if (addr == A_CTRL_B) rdata = {ponc_q, 1'b0, fmt_q, cnt_q};
        end else if (addr < HALF_LIM) begin
            rdata = ram_rd;
        end
    end

endmodule

// File: rtl/nbr_banked_checker.sv
module nbr_banked_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sck_lvl,
    input logic       sysr_on,
    input logic       ponc_q,
    input logic [1:0] mode_q,
    input logic       tst_q,
    input logic       tps_q,
    input logic       adj_q,
    input logic       fmt_q,
    input logic       cnt_q
);

    a_r7_ctrl_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        sysr_on |-> (mode_q == 2'b00 && !tst_q && !tps_q && !adj_q && !fmt_q && !cnt_q));

    a_r8_held_past_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sysr_on) |=> sysr_on);

    a_r8_release_on_sck_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sysr_on) |-> ($past(sck_lvl, 2) && !$past(sck_lvl)));

    a_r9_ponc_with_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ponc_q) |-> $fell(sysr_on));

    a_r9_ponc_no_reset_set: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(ponc_q));

endmodule

bind nibble_bank_regs nbr_banked_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck_lvl (sck_lvl),
    .sysr_on (sysr_on),
    .ponc_q  (ponc_q),
    .mode_q  (mode_q),
    .tst_q   (tst_q),
    .tps_q   (tps_q),
    .adj_q   (adj_q),
    .fmt_q   (fmt_q),
    .cnt_q   (cnt_q)
);

// File: tb/test_nibble_bank_regs.sv
module test_nibble_bank_regs;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_lvl = 1'b1;
    logic       sck_lvl = 1'b0;
    logic       wr_stb = 1'b0;
    logic [5:0] addr = '0;
    logic [3:0] wdata = '0;
    logic [3:0] rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    nibble_bank_regs i_nibble_bank_regs (
        .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .sck_lvl(sck_lvl),
        .wr_stb(wr_stb), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [3:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        for (int i = 0; i < 13; i++) begin
            logic [3:0] e;
            e = (i == 4) ? 4'h2 : ((i == 5 || i == 7 || i == 9) ? 4'h1 : 4'h0);
            rd_chk("R6 counter init", 6'(i), e);
        end
        rd_chk("R6 ctrl_a zero", 6'd61, 4'h0);
        rd_chk("R6 ctrl_b ponc", 6'd62, 4'h8);
        rd_chk("R6 ctrl_c zero", 6'd63, 4'h0);
    endtask

    task automatic t_time_bank;
        wr(6'd63, 4'h1);
        rd_chk("R5 mode 01 stored", 6'd63, 4'h1);
        wr(6'd0, 4'h9);
        rd_chk("R1 mode 01 counter", 6'd0, 4'h9);
        wr(6'd1, 4'hF);
        rd_chk("R3 mask addr1", 6'd1, 4'h7);
        wr(6'd5, 4'hF);
        rd_chk("R3 mask addr5", 6'd5, 4'hB);
        wr(6'd8, 4'hF);
        rd_chk("R3 mask addr8", 6'd8, 4'h3);
        wr(6'd10, 4'hF);
        rd_chk("R3 mask addr10", 6'd10, 4'h1);
        wr(6'd12, 4'hF);
        rd_chk("R3 mask addr12", 6'd12, 4'hF);
        wr(6'd20, 4'h5);
        rd_chk("R1 gap reads zero", 6'd20, 4'h0);
        wr(6'd61, 4'hF);
        rd_chk("R3 ctrl_a fixed zero", 6'd61, 4'hC);
        wr(6'd63, 4'h0);
        rd_chk("R1 mode 00 counter", 6'd0, 4'h9);
    endtask

    task automatic t_ctrl_bits;
        wr(6'd62, 4'hF);
        rd_chk("R4 ctrl_b busy zero ponc kept", 6'd62, 4'hB);
        rd_chk("R10 counter held at init", 6'd0, 4'h0);
        wr(6'd0, 4'h5);
        rd_chk("R10 counter write ignored", 6'd0, 4'h0);
        wr(6'd62, 4'h2);
        rd_chk("R4 fmt only", 6'd62, 4'hA);
        wr(6'd0, 4'h5);
        rd_chk("R10 counter writable after clear", 6'd0, 4'h5);
        wr(6'd63, 4'h4);
        rd_chk("R5 test bit stored", 6'd63, 4'h4);
        wr(6'd63, 4'h0);
    endtask

    task automatic t_ram;
        wr(6'd63, 4'h2);
        wr(6'd0, 4'hA);
        wr(6'd59, 4'h3);
        wr(6'd61, 4'h0);
        wr(6'd63, 4'h3);
        wr(6'd0, 4'h5);
        wr(6'd59, 4'hC);
        rd_chk("R2 upper half addr0", 6'd0, 4'h5);
        rd_chk("R2 upper half addr59", 6'd59, 4'hC);
        rd_chk("R2 ctrl_c in ram bank", 6'd63, 4'h3);
        rd_chk("R2 ctrl_a hidden", 6'd61, 4'h0);
        wr(6'd60, 4'h7);
        rd_chk("R2 gap reads zero", 6'd60, 4'h0);
        wr(6'd63, 4'h2);
        rd_chk("R2 lower half addr0", 6'd0, 4'hA);
        rd_chk("R2 lower half addr59", 6'd59, 4'h3);
        wr(6'd63, 4'h0);
        rd_chk("R2 ctrl_a kept", 6'd61, 4'hC);
    endtask

    task automatic release_seq(input bit first);
        sck_lvl = 1'b1; idle(1);
        sck_lvl = 1'b0; idle(1);
        if (first) rd_chk("R8 sck fall before cs rise", 6'd63, 4'h8);
        cs_lvl = 1'b0; idle(1);
        cs_lvl = 1'b1; idle(1);
        if (first) rd_chk("R8 cs rise alone", 6'd63, 4'h8);
        sck_lvl = 1'b1; idle(1);
        if (first) rd_chk("R8 sck high not yet", 6'd63, 4'h8);
        sck_lvl = 1'b0;
    endtask

    task automatic t_sysr;
        wr(6'd2, 4'h5);
        wr(6'd63, 4'hB);
        rd_chk("R7 sysr set", 6'd63, 4'h8);
        rd_chk("R7 ctrl_a cleared", 6'd61, 4'h0);
        rd_chk("R7 ctrl_b cleared ponc kept", 6'd62, 4'h8);
        rd_chk("R7 counter reinit", 6'd2, 4'h0);
        wr(6'd62, 4'h3);
        rd_chk("R7 write ignored during hold", 6'd62, 4'h8);
        release_seq(1'b1);
        rd_chk("R8 released on sck fall", 6'd63, 4'h0);
        rd_chk("R9 ponc cleared", 6'd62, 4'h0);
        wr(6'd63, 4'h2);
        rd_chk("R7 ram kept", 6'd0, 4'hA);
        wr(6'd63, 4'h8);
        release_seq(1'b0);
        rd_chk("R8 second release", 6'd63, 4'h0);
        rd_chk("R9 ponc stays clear", 6'd62, 4'h0);
    endtask

    initial begin
        t_reset;
        t_time_bank;
        t_ctrl_bits;
        t_ram;
        t_sysr;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule